// File: doc/BRIEF.md
# ADC Serial Port and Conversion Sequencer

This block is the digital control for a converter with a serial interface. A master selects the device by pulling the already-filtered chip-select input low. It then clocks a frame of 12 SCLK periods. On the first rising edges the block collects a multiplexer address from DIN, most significant bit first. On the falling edges it presents the previous 12-bit conversion result on DOUT, most significant bit first. A sampling window follows the address. When the frame ends, a conversion runs for a fixed, parameterised number of ACLK rising edges. At the end the block captures a new result word from a behavioural converter stub.

All of SCLK, ACLK and chip-select are sampled by a single fast system clock, and their edges are detected in that domain. The master may use either of two modes. In the first, it raises chip-select while the conversion runs. In the second, it keeps chip-select low and SCLK idle, and DOUT is driven with the first result bit the moment the conversion ends. Any SCLK edge during a chip-select-low conversion is flagged as a protocol error.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, dout_en, busy, mux_addr and proto_err are all 0.
- R2: While cs_n is 1 and no conversion runs, dout_en is 0, and SCLK and DIN edges change neither mux_addr nor the result bit order of the next frame.
- R3: With cs_n low and no conversion running, DIN is captured on the first ADDR_W sampled SCLK rising edges, first bit as address MSB. mux_addr takes the new value in the cycle after the ADDR_W-th rising edge is seen, and holds it otherwise.
- R4: At the start of each frame dout shows bit 11 of the held result word. Each SCLK falling edge after a rising edge advances dout one bit toward bit 0.
- R5: The SCLK falling edge that follows the 12th rising edge of a frame starts a conversion. The conversion ends on the CONV_CYC-th (48 to 52, default 50) subsequent ACLK rising edge. busy is 1 from the ADDR_W-th rising edge of a frame until the conversion ends.
- R6: dout_en is 1 exactly when cs_n is 0 and no conversion is running.
- R7: When a conversion ends with cs_n still low, dout_en goes to 1 with bit 11 of the new result, and the next frame proceeds without a chip-select toggle.
- R8: An SCLK edge during a conversion with cs_n low sets proto_err and shifts nothing. A cs_n rising edge clears proto_err.
- R9: Raising cs_n before a frame completes abandons it. The next frame restarts from result bit 11 and address bit 0, and an address with fewer than ADDR_W bits shifted in is not latched.
- R10: The result input is captured only on the ACLK edge that ends a conversion. Later changes do not affect dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial and converter strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Filtered chip-select, active low |
| sclk | input | 1 | Serial shift clock from the master |
| din | input | 1 | Serial address input |
| aclk | input | 1 | Conversion clock |
| result | input | RES_W | Conversion word from the converter stub |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Output driver enable for dout |
| mux_addr | output | ADDR_W | Latched multiplexer address |
| busy | output | 1 | Sampling or conversion in progress |
| proto_err | output | 1 | SCLK activity seen during a chip-select-low conversion |

## Verification
The bench looks for off-by-one faults in the conversion length. A design that ends one ACLK edge early or late shows busy dropping in the wrong cycle. It also probes the chip-select-low mode. A design that ignored that mode would leave DOUT disabled after conversion, or would shift on stray SCLK edges and lose bit 11 of the next word. Frames are cut short both before and after the address is complete. A design that latched partial addresses, or kept its bit position across a deselect, returns a rotated result word. The result input is changed after a conversion ends, which exposes a design that samples it continuously.

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int RES_W    = 12,
  parameter int ADDR_W   = 4,
  parameter int CONV_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              aclk,
  input  logic [RES_W-1:0]  result,
  output logic              dout,
  output logic              dout_en,
  output logic [ADDR_W-1:0] mux_addr,
  output logic              busy,
  output logic              proto_err
);
  localparam int CNT_W = $clog2(RES_W + 1);
  localparam int CC_W  = $clog2(CONV_CYC + 1);

  logic              sclk_q, aclk_q, cs_q, conv;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CC_W-1:0]   conv_cnt;
  logic [ADDR_W-1:0] addr_sr;
  logic [RES_W-1:0]  res_q, out_sr;

  wire sclk_rise = sclk & ~sclk_q;
  wire sclk_fall = ~sclk & sclk_q;
  wire aclk_rise = aclk & ~aclk_q;
  wire cs_rise   = cs_n & ~cs_q;
  wire sel       = ~cs_n & ~conv;
  wire [ADDR_W-1:0] addr_nx = {addr_sr[ADDR_W-2:0], din};

  assign dout    = out_sr[RES_W-1];
  assign dout_en = sel;
  assign busy    = conv | (bit_cnt >= CNT_W'(ADDR_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      aclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      conv      <= 1'b0;
      bit_cnt   <= '0;
      conv_cnt  <= '0;
      addr_sr   <= '0;
      mux_addr  <= '0;
      res_q     <= '0;
      out_sr    <= '0;
      proto_err <= 1'b0;
    end else begin
      sclk_q <= sclk;
      aclk_q <= aclk;
      cs_q   <= cs_n;
      if (conv) begin
        if (aclk_rise) begin
          if (conv_cnt == CC_W'(CONV_CYC - 1)) begin
            conv     <= 1'b0;
            conv_cnt <= '0;
            res_q    <= result;
            out_sr   <= result;
            bit_cnt  <= '0;
          end else begin
            conv_cnt <= conv_cnt + 1'b1;
          end
        end
        if (!cs_n && (sclk_rise || sclk_fall)) proto_err <= 1'b1;
      end else if (cs_n) begin
        bit_cnt <= '0;
        out_sr  <= res_q;
      end else begin
        if (sclk_rise) begin
          if (bit_cnt < CNT_W'(ADDR_W)) addr_sr <= addr_nx;
          if (bit_cnt == CNT_W'(ADDR_W - 1)) mux_addr <= addr_nx;
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (sclk_fall) begin
          if (bit_cnt == CNT_W'(RES_W)) begin
            conv     <= 1'b1;
            conv_cnt <= '0;
          end else if (bit_cnt != '0) begin
            out_sr <= {out_sr[RES_W-2:0], 1'b0};
          end
        end
      end
      if (cs_rise) proto_err <= 1'b0;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sel && bit_cnt == CNT_W'(ADDR_W - 1)) |=> $stable(mux_addr)); // R3
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && !aclk_rise) |=> conv); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> (conv_cnt < CC_W'(CONV_CYC))); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && !cs_n && (sclk_rise || sclk_fall)) |=> proto_err); // R8
  AST_NO_SHIFT_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (conv && !aclk_rise) |=> $stable(out_sr)); // R8
  AST_RESULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv) |-> (out_sr == $past(result))); // R10
endmodule

// File: tb/adc_serial_seq_test.sv
module adc_serial_seq_test;
  localparam int RW = 12, AW = 4, CONV = 50;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, din = 0, aclk = 0;
  logic [RW-1:0] result = '0;
  logic dout, dout_en, busy, proto_err;
  logic [AW-1:0] mux_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  adc_serial_seq #(.RES_W(RW), .ADDR_W(AW), .CONV_CYC(CONV)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .aclk(aclk),
    .result(result), .dout(dout), .dout_en(dout_en), .mux_addr(mux_addr),
    .busy(busy), .proto_err(proto_err));

  always #10 clk = ~clk;

  initial forever begin
    repeat (2) @(posedge clk);
    #2 aclk = ~aclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  bit ps, pa, pc, mconv, merr;
  int mn, mcc, midx;
  logic [AW-1:0] macc, maddr;
  logic [RW-1:0] mres;
  always @(posedge clk) begin
    bit sr, sf, ar, cr;
    if (!rst_n) begin
      ps = 0; pa = 0; pc = 1; mconv = 0; merr = 0; mn = 0; mcc = 0; midx = 0;
      macc = 0; maddr = 0; mres = 0;
    end else begin
      sr = sclk && !ps; sf = !sclk && ps; ar = aclk && !pa; cr = cs_n && !pc;
      if (mconv) begin
        if (ar) begin
          mcc++;
          if (mcc == CONV) begin mconv = 0; mcc = 0; mres = result; midx = 0; mn = 0; end
        end
        if (!cs_n && (sr || sf)) merr = 1;
      end else if (cs_n) begin
        mn = 0; midx = 0;
      end else begin
        if (sr) begin
          if (mn < AW) begin macc = {macc[AW-2:0], din}; if (mn == AW - 1) maddr = macc; end
          mn++;
        end
        if (sf) begin
          if (mn == RW) begin mconv = 1; mcc = 0; end
          else if (mn > 0) midx++;
        end
      end
      if (cr) merr = 0;
      ps = sclk; pa = aclk; pc = cs_n;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 dout", dout, mres[RW-1-midx]);
    chk("R6 dout_en", dout_en, !cs_n && !mconv);
    chk("R5 busy", busy, mconv || mn >= AW);
    chk("R3 mux_addr", mux_addr, maddr);
    chk("R8 proto_err", proto_err, merr);
  end

  task automatic tick(input int k);
    repeat (k) begin @(posedge clk); #2; end
  endtask

  task automatic frame(input logic [AW-1:0] a, input int n, output logic [RW-1:0] w);
    cs_n = 0; w = '0;
    tick(2);
    for (int i = 0; i < n; i++) begin
      din = (i < AW) ? a[AW-1-i] : 1'b0;
      tick(2);
      w = {w[RW-2:0], dout};
      sclk = 1; tick(3);
      sclk = 0; tick(1);
    end
    tick(2);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin tick(1); n++; end
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] w;
    int n;
    tick(5);
    rst_n = 1; tick(1);
    chk("R1 dout_en", dout_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mux_addr", mux_addr, 0);
    chk("R1 proto_err", proto_err, 0);
    result = 12'hA5C;
    din = 1;
    for (int i = 0; i < 5; i++) begin sclk = 1; tick(3); sclk = 0; tick(3); end
    chk("R2 mux_addr", mux_addr, 0);
    chk("R2 dout_en", dout_en, 0);
    // normal mode frame
    frame(4'hB, 12, w);
    chk("R4 word0", w, 0);
    chk("R3 addr", mux_addr, 4'hB);
    cs_n = 1;
    wait_idle(n);
    chk("R5 length", (n >= CONV*4-8 && n <= CONV*4+4), 1);
    frame(4'h3, 12, w);
    chk("R4 word1", w, 12'hA5C);
    chk("R3 addr2", mux_addr, 4'h3);
    result = 12'h3E1;
    cs_n = 1;
    wait_idle(n);
    result = 12'hFFF;
    // chip-select low mode
    frame(4'h6, 12, w);
    chk("R10 word", w, 12'h3E1);
    chk("R6 en off in conv", dout_en, 0);
    result = 12'h5A3;
    wait_idle(n);
    chk("R7 dout_en", dout_en, 1);
    chk("R7 dout bit11", dout, 0);
    frame(4'h9, 12, w);
    chk("R7 word", w, 12'h5A3);
    result = 12'hC0F;
    sclk = 1; tick(3); sclk = 0; tick(3);
    chk("R8 err set", proto_err, 1);
    chk("R8 addr", mux_addr, 4'h9);
    wait_idle(n);
    chk("R8 dout bit11", dout, 1);
    frame(4'h2, 12, w);
    chk("R8 word intact", w, 12'hC0F);
    cs_n = 1; tick(2);
    chk("R8 err clear", proto_err, 0);
    wait_idle(n);
    // abandoned frames
    frame(4'hF, 2, w);
    cs_n = 1; tick(3);
    chk("R9 partial addr", mux_addr, 4'h2);
    frame(4'h7, 6, w);
    chk("R9 busy sampling", busy, 1);
    cs_n = 1; tick(3);
    chk("R9 addr latched", mux_addr, 4'h7);
    chk("R9 busy drop", busy, 0);
    frame(4'h1, 12, w);
    chk("R9 full word", w, 12'hC0F);
    cs_n = 1;
    wait_idle(n);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule